// File: doc/BRIEF.md
# Indirect Eight-Line Transmit Queue Controller

This block serves eight asynchronous output lines from one host register window. A single control/status word carries a line number and a register code, and a second word, the indirect window, then reaches that line's transmit queue, its line control byte or its modem-signal bytes. Each line owns a 32-character queue; characters leave it towards an external bit shifter over a per-line valid/ready port.

When a line's queue runs dry while that line is enabled, or when the host flushes it, the line is marked pending. The lowest-numbered pending line is shown in the control/status word together with a done flag, and a read of that word retires the line shown. An interrupt pin follows the done flag when the interrupt enable is set.

The transmit port obeys the usual stream rules: `tx_valid[i]` stays high and `tx_data` for line i stays unchanged until `tx_ready[i]` is seen high at a rising edge; the shifter may hold `tx_ready` low for any length of time, and the queue simply fills. Host accesses are single-cycle: a write takes effect at the edge where `host_wr` is high, and `host_rdata` is valid combinationally while `host_rd` is high.

Top module: `tx_silo_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x0000, every queue count reads 0, all `tx_valid` bits, `brk_out`, `mdm_out` and `irq` are low.
- R2: With register code 0 (control/status bits 4:3 = 00) and line L in bits 2:0, a low-byte indirect write appends the byte to line L's queue; the indirect low byte then reads the queue fill count, and the characters leave `tx_data` of line L in write order, held stable while `tx_ready` is low.
- R3: An indirect character write to a line whose queue already holds 32 characters is ignored: the count stays 32 and that character is never sent.
- R4: Line control bit 0 (transmit enable) gates output: while clear, `tx_valid` of the line stays low and the queue keeps its contents; setting it resumes output in order.
- R5: Writing line control (code 1, control/status bits 4:3 = 01, low byte) with bit 4 set empties that line's queue in one cycle, the bit reads back as 0, and the line becomes pending.
- R6: When the last character of an enabled line is taken, the line becomes pending: the control/status word shows bit 15 set and the line in bits 10:8, and `irq` equals bit 15 AND the interrupt enable in bit 14.
- R7: With several lines pending the lowest-numbered one is shown; a read of the control/status word retires the shown line, after which the next one appears, and bit 15 clears when none remains.
- R8: Line control bit 3 drives `brk_out` of that line high for exactly as long as it is set.
- R9: Under code 1 the indirect high byte bits 4:0 write and read the line's modem-output bits on `mdm_out[5L+4:5L]`; under code 0 the indirect high byte reads `mdm_in[8L+7:8L]`.
- R10: A control/status write with bit 5 set empties all queues and clears all line control, modem-output and pending state, the interrupt enable and the select field; bit 5 reads back as 0.
- R11: A character write that lands in the same cycle as the shifter taking a line's only character keeps the count at 1 and does not mark the line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a control/status read retires the shown line) |
| host_win | input | 1 | 0 selects the control/status word, 1 the indirect window |
| host_be | input | 2 | Byte enables for indirect writes (bit 0 low byte, bit 1 high byte) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| irq | output | 1 | Transmit interrupt request |
| tx_valid | output | NLINES | Per-line character available |
| tx_ready | input | NLINES | Per-line shifter accepts |
| tx_data | output | 8*NLINES | Per-line character, line i at bits 8i+7:8i |
| brk_out | output | NLINES | Per-line force-spacing (break) level |
| mdm_out | output | 5*NLINES | Per-line modem-output bits |
| mdm_in | input | 8*NLINES | Per-line received modem status |

## Verification
The collision of interest is a host character write arriving in the very cycle the shifter takes a line's only queued character, so the queue neither empties nor grows. The bench provokes it by raising that line's ready for exactly one cycle alongside the write, then judges it by the count reading 1 and the done flag staying clear, before letting the second character drain and confirming the line then reports. A second overlap, several lines draining together, is judged by the order in which successive control/status reads report them.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CSR_TI_BIT  = 15;
  localparam int CSR_TIE_BIT = 14;
  localparam int CSR_CLR_BIT = 5;
  localparam int CSR_LINE_LO = 8;

  localparam logic [1:0] CODE_TBUF = 2'b00;
  localparam logic [1:0] CODE_LCTL = 2'b01;

  localparam int LC_TE    = 0;
  localparam int LC_FLUSH = 4;
  localparam int LC_BRK   = 3;
  localparam int LC_W     = 6;
  localparam int MO_W     = 5;
endpackage

// File: rtl/tsc_fifo.sv
module tsc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drained
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign empty   = (count == '0);
  assign rdata   = mem[rp];
  assign drained = pop_ok && !push_ok && (count == CW'(1)) && !clr;

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok)  rp <= rp + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && push && !pop && !clr) |=> (count == CW'(DEPTH))); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R5
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> empty); // R6
endmodule

// File: rtl/tsc_pend.sv
module tsc_pend #(
  parameter int N   = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [N-1:0]  set_vec,
  input  logic          ack,
  output logic          ti,
  output logic [LW-1:0] line
);
  logic [N-1:0] pend_q, ack_mask;

  always_comb begin
    line = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) line = LW'(i);
    end
  end

  assign ti       = |pend_q;
  assign ack_mask = ack ? (N'(1) << line) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (clr) pend_q <= '0;
    else          pend_q <= (pend_q & ~ack_mask) | set_vec;
  end

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_vec[line]) |=> !pend_q[$past(line)]); // R7
  AST_EVENT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec != '0) && !clr) |=> ti); // R6
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ti |-> ((pend_q & ((N'(1) << line) - N'(1))) == '0)); // R7
endmodule

// File: rtl/tx_silo_ctrl.sv
module tx_silo_ctrl
  import tsc_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DEPTH  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic                 host_win,
  input  logic [1:0]           host_be,
  input  logic [15:0]          host_wdata,
  output logic [15:0]          host_rdata,
  output logic                 irq,
  output logic [NLINES-1:0]    tx_valid,
  input  logic [NLINES-1:0]    tx_ready,
  output logic [NLINES*8-1:0]  tx_data,
  output logic [NLINES-1:0]    brk_out,
  output logic [NLINES*5-1:0]  mdm_out,
  input  logic [NLINES*8-1:0]  mdm_in
);
  localparam int LW = $clog2(NLINES);
  localparam int CW = $clog2(DEPTH) + 1;

  logic            tie_q;
  logic [4:0]      sel_q;
  logic [LC_W-1:0] lctl_q [NLINES];
  logic [MO_W-1:0] mout_q [NLINES];
  logic [CW-1:0]   cnt [NLINES];
  logic [NLINES-1:0] set_vec;
  logic [LW-1:0]   cur, pend_line;
  logic [1:0]      code;
  logic            csr_wr, mreset, ind_lo, ind_hi, ti, ack;

  assign cur    = sel_q[LW-1:0];
  assign code   = sel_q[4:3];
  assign csr_wr = host_wr && !host_win;
  assign mreset = csr_wr && host_wdata[CSR_CLR_BIT];
  assign ind_lo = host_wr && host_win && host_be[0];
  assign ind_hi = host_wr && host_win && host_be[1];
  assign ack    = host_rd && !host_win && ti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || mreset) begin
      tie_q <= 1'b0;
      sel_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        lctl_q[i] <= '0;
        mout_q[i] <= '0;
      end
    end else begin
      if (csr_wr) begin
        tie_q <= host_wdata[CSR_TIE_BIT];
        sel_q <= host_wdata[4:0];
      end
      if (ind_lo && code == CODE_LCTL) begin
        lctl_q[cur] <= host_wdata[LC_W-1:0] & ~(LC_W'(1) << LC_FLUSH);
      end
      if (ind_hi && code == CODE_LCTL) begin
        mout_q[cur] <= host_wdata[8 +: MO_W];
      end
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic push, flush, pop, empty, drained;
    assign push  = ind_lo && code == CODE_TBUF && cur == LW'(g);
    assign flush = ind_lo && code == CODE_LCTL && cur == LW'(g) && host_wdata[LC_FLUSH];
    assign tx_valid[g] = !empty && lctl_q[g][LC_TE];
    assign pop   = tx_valid[g] && tx_ready[g];

    tsc_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(flush || mreset),
      .push(push), .wdata(host_wdata[7:0]), .pop(pop),
      .rdata(tx_data[g*8 +: 8]), .count(cnt[g]),
      .empty(empty), .drained(drained)
    );

    assign set_vec[g]          = drained || flush;
    assign brk_out[g]          = lctl_q[g][LC_BRK];
    assign mdm_out[g*5 +: 5]   = mout_q[g];

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[g] && !tx_ready[g] && !host_wr)
      |=> (tx_valid[g] && $stable(tx_data[g*8 +: 8]))); // R2
    AST_PAUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!lctl_q[g][LC_TE] && !host_wr) |=> $stable(cnt[g])); // R4
  end

  tsc_pend #(.N(NLINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .set_vec(set_vec),
    .ack(ack), .ti(ti), .line(pend_line)
  );

  assign irq = ti && tie_q;

  always_comb begin
    host_rdata = '0;
    if (!host_win) begin
      host_rdata[CSR_TI_BIT]            = ti;
      host_rdata[CSR_TIE_BIT]           = tie_q;
      host_rdata[CSR_LINE_LO +: LW]     = pend_line;
      host_rdata[4:0]                   = sel_q;
    end else if (code == CODE_TBUF) begin
      host_rdata[7:0]  = 8'(cnt[cur]);
      host_rdata[15:8] = mdm_in[cur*8 +: 8];
    end else if (code == CODE_LCTL) begin
      host_rdata[LC_W-1:0]  = lctl_q[cur];
      host_rdata[8 +: MO_W] = mout_q[cur];
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (host_rdata[CSR_TI_BIT] || host_win)); // R6
endmodule

// File: tb/tx_silo_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_silo_ctrl_tb_top;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_win = 0;
  logic [1:0] host_be = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic irq;
  logic [NL-1:0] tx_valid, tx_ready = '0, brk_out;
  logic [NL*8-1:0] tx_data, mdm_in;
  logic [NL*5-1:0] mdm_out;

  int nchk = 0, nfail = 0;
  bit done = 0, tie_b = 0;
  logic [7:0] exp_q [NL][$];

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < NL; i++) begin : g_min
    assign mdm_in[i*8 +: 8] = 8'hA0 + 8'(i);
  end

  tx_silo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_win(host_win), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .brk_out(brk_out),
    .mdm_out(mdm_out), .mdm_in(mdm_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [15:0] d);
    @(negedge clk);
    host_wr = 1; host_win = 0; host_be = 2'b11; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic sel(input int line, input int code);
    logic [15:0] d;
    d = '0;
    d[14] = tie_b;
    d[4:3] = 2'(code);
    d[2:0] = 3'(line);
    wr_csr(d);
  endtask

  task automatic wr_ind(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1; host_win = 1; host_be = be; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input bit win, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1; host_win = win;
    #2 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  // driver: line must already be selected with code 0
  task automatic push_char(input int line, input logic [7:0] c);
    if (exp_q[line].size() < 32) exp_q[line].push_back(c);
    wr_ind(2'b01, {8'h00, c});
  endtask

  // monitor: compares every accepted character with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        for (int i = 0; i < NL; i++) begin
          if (tx_valid[i] && tx_ready[i]) begin
            if (exp_q[i].size() == 0) begin
              check(0, "R2 unexpected char", int'(tx_data[i*8 +: 8]), 0);
            end else begin
              check(tx_data[i*8 +: 8] == exp_q[i][0], "R2 char order",
                    int'(tx_data[i*8 +: 8]), int'(exp_q[i][0]));
              void'(exp_q[i].pop_front());
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, d);
    check(d == 16'h0000, "R1 csr after reset", d, 0);
    check(tx_valid == '0 && irq == 0 && brk_out == '0 && mdm_out == '0,
          "R1 outputs after reset", {tx_valid, brk_out}, 0);
    sel(4, 0);
    rd(1, d);
    check(d[7:0] == 8'd0, "R1 count after reset", d[7:0], 0);

    // R2 / R4 / R6 : line 2, load while paused, then resume
    tie_b = 1;
    sel(2, 0);
    push_char(2, 8'h41); push_char(2, 8'h42); push_char(2, 8'h43);
    rd(1, d);
    check(d[7:0] == 8'd3, "R2 fill count", d[7:0], 3);
    tx_ready[2] = 1;
    repeat (3) @(negedge clk);
    check(tx_valid[2] == 0, "R4 paused valid low", tx_valid[2], 0);
    rd(1, d);
    check(d[7:0] == 8'd3, "R4 paused keeps contents", d[7:0], 3);
    sel(2, 1);
    wr_ind(2'b01, 16'h0001);
    repeat (10) @(negedge clk);
    check(exp_q[2].size() == 0, "R4 resume drained", exp_q[2].size(), 0);
    #2 check(irq == 1, "R6 irq raised", irq, 1);
    rd(0, d);
    check(d[15] == 1 && d[10:8] == 3'd2, "R6 done flag and line", d, 16'h8200);
    rd(0, d);
    check(d[15] == 0, "R7 retired", d[15], 0);
    #2 check(irq == 0, "R6 irq cleared", irq, 0);

    // R3 full queue on line 5
    sel(5, 0);
    for (int k = 0; k < 34; k++) push_char(5, 8'(k + 8'h10));
    rd(1, d);
    check(d[7:0] == 8'd32, "R3 count saturates", d[7:0], 32);
    tx_ready[5] = 1;
    sel(5, 1);
    wr_ind(2'b01, 16'h0001);
    repeat (40) @(negedge clk);
    check(exp_q[5].size() == 0, "R3 exactly 32 sent", exp_q[5].size(), 0);
    sel(5, 0);
    rd(1, d);
    check(d[7:0] == 8'd0, "R3 empty after drain", d[7:0], 0);
    rd(0, d);
    check(d[15] && d[10:8] == 3'd5, "R6 line 5 reported", d, 16'h8500);

    // R7 priority: lines 6 and 1
    tx_ready[6] = 1; tx_ready[1] = 1;
    sel(6, 1); wr_ind(2'b01, 16'h0001);
    sel(1, 1); wr_ind(2'b01, 16'h0001);
    sel(6, 0); push_char(6, 8'h66);
    sel(1, 0); push_char(1, 8'h11);
    repeat (5) @(negedge clk);
    rd(0, d);
    check(d[15] && d[10:8] == 3'd1, "R7 lowest line first", d[10:8], 1);
    rd(0, d);
    check(d[15] && d[10:8] == 3'd6, "R7 next line", d[10:8], 6);
    rd(0, d);
    check(d[15] == 0, "R7 none left", d[15], 0);

    // R5 flush on line 3
    sel(3, 0);
    push_char(3, 8'h31); push_char(3, 8'h32); push_char(3, 8'h33); push_char(3, 8'h34);
    sel(3, 1);
    wr_ind(2'b01, 16'h0010);
    exp_q[3].delete();
    rd(1, d);
    check(d[4] == 0, "R5 flush bit reads 0", d[4], 0);
    sel(3, 0);
    rd(1, d);
    check(d[7:0] == 8'd0, "R5 queue emptied", d[7:0], 0);
    rd(0, d);
    check(d[15] && d[10:8] == 3'd3, "R5 flush reports line", d, 16'h8300);
    tx_ready[3] = 1;
    sel(3, 1); wr_ind(2'b01, 16'h0001);
    repeat (3) @(negedge clk);
    check(tx_valid[3] == 0, "R5 nothing left to send", tx_valid[3], 0);

    // R8 break
    sel(4, 1);
    wr_ind(2'b01, 16'h0008);
    #1 check(brk_out == 8'h10, "R8 break on", brk_out, 8'h10);
    repeat (4) @(negedge clk);
    check(brk_out == 8'h10, "R8 break held", brk_out, 8'h10);
    wr_ind(2'b01, 16'h0000);
    #1 check(brk_out == 8'h00, "R8 break off", brk_out, 0);

    // R9 modem bits
    sel(0, 1);
    wr_ind(2'b10, 16'h1500);
    #1 check(mdm_out[4:0] == 5'h15, "R9 modem out", mdm_out[4:0], 5'h15);
    rd(1, d);
    check(d[12:8] == 5'h15, "R9 modem readback", d[12:8], 5'h15);
    sel(3, 0);
    rd(1, d);
    check(d[15:8] == 8'hA3, "R9 modem in", d[15:8], 8'hA3);

    // R11 push and pop in the same cycle on line 7
    sel(7, 1); wr_ind(2'b01, 16'h0001);
    sel(7, 0); push_char(7, 8'h71);
    @(negedge clk);
    tx_ready[7] = 1;
    exp_q[7].push_back(8'h72);
    host_wr = 1; host_win = 1; host_be = 2'b01; host_wdata = 16'h0072;
    @(negedge clk);
    tx_ready[7] = 0; host_wr = 0;
    rd(1, d);
    check(d[7:0] == 8'd1, "R11 count stays 1", d[7:0], 1);
    rd(0, d);
    check(d[15] == 0, "R11 no done event", d[15], 0);
    tx_ready[7] = 1;
    repeat (4) @(negedge clk);
    rd(0, d);
    check(d[15] && d[10:8] == 3'd7, "R11 later drain reports", d, 16'h8700);

    // R10 master reset
    sel(0, 0);
    tx_ready[0] = 0;
    push_char(0, 8'h01); push_char(0, 8'h02);
    wr_csr(16'h4020);
    tie_b = 0;
    for (int i = 0; i < NL; i++) exp_q[i].delete();
    rd(0, d);
    check(d == 16'h0000, "R10 csr cleared", d, 0);
    check(mdm_out == '0 && irq == 0, "R10 modem and irq cleared", mdm_out[4:0], 0);
    sel(0, 0);
    rd(1, d);
    check(d[7:0] == 8'd0, "R10 queue cleared", d[7:0], 0);
    sel(0, 1);
    rd(1, d);
    check(d[7:0] == 8'd0, "R10 line control cleared", d[7:0], 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule